// File: doc/BRIEF.md
# UART Channel Mode Data Router

This block sits between a serial receiver, the CPU data register and the two byte FIFOs of a UART, and decides where each byte goes. A 2-bit channel mode selects one of four routings. Normal mode feeds received bytes to the receive queue and CPU writes to the transmit queue. Echo mode copies every received byte into both queues. Local loopback sends CPU writes back into the receive queue. Remote loopback turns received bytes straight around into the transmit queue. The receive and transmit FIFOs live inside the block. The transmit FIFO drains through a valid/ready port toward the serializer. The CPU pops the receive FIFO through a data-register read strobe.

The block also holds the control register. Enable and disable bits gate each path. Two bits flush the FIFOs and never read back as set. The receiver-ready signal reflects free space in whichever queues the current mode writes. A CPU push into a full queue is dropped and raises a one-cycle overrun pulse.

Top module: `uart_chan_router`

## Requirements
- R1: After reset the control readback is 0x128 (RX disabled by bit 3, TX disabled by bit 5, bit 8 set), both FIFO counts are 0 and `tx_valid` is low.
- R2: With `chmode` = 0 (normal), an accepted receiver byte is pushed into the RX FIFO and a CPU data write is pushed into the TX FIFO.
- R3: With `chmode` = 1 (echo), an accepted receiver byte is pushed into both FIFOs. CPU data writes are discarded.
- R4: With `chmode` = 2 (local loopback), CPU data writes are pushed into the RX FIFO, and receiver bytes are accepted and discarded. With `chmode` = 3 (remote loopback), receiver bytes go only to the TX FIFO and CPU data writes are discarded.
- R5: `rx_ready` requires a non-full RX FIFO in modes 0 and 1 and a non-full TX FIFO in modes 1 and 3. It is always high in mode 2. A receiver byte is taken only in a cycle where `rx_valid` and `rx_ready` are both high, at most one per clock.
- R6: The RX path is active only while control bit 2 = 1 and bit 3 = 0. When it is inactive, RX pushes and CPU pops are ignored and the FIFO contents are kept. The TX path uses bits 4 (enable) and 5 (disable) the same way for pushes. Draining toward the serializer does not depend on these bits.
- R7: A control write with bit 0 set empties the RX FIFO, and one with bit 1 set empties the TX FIFO. Bits 1:0 always read back as 0.
- R8: `dr_rdata` is 0 when the RX FIFO is empty or the RX path is inactive. Otherwise it shows the oldest RX byte, which a `dr_rd` pops.
- R9: A push with the path active into a full FIFO is dropped, leaves the count unchanged, and drives `ovr_evt` high for the one cycle after the push.
- R10: `tx_valid` is high while the TX FIFO holds data. Bytes leave in push order, one per cycle in which `tx_valid` and `tx_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chmode | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control write value |
| ctrl_q | output | 9 | Control register readback |
| rx_valid | input | 1 | Receiver byte valid |
| rx_data | input | DW | Receiver byte |
| rx_ready | output | 1 | Block can take a receiver byte |
| dr_wr | input | 1 | CPU data-register write strobe |
| dr_wdata | input | DW | CPU write byte |
| dr_rd | input | 1 | CPU data-register read strobe |
| dr_rdata | output | DW | CPU read byte (0 when nothing to read) |
| tx_valid | output | 1 | TX FIFO has a byte for the serializer |
| tx_data | output | DW | Oldest TX byte |
| tx_ready | input | 1 | Serializer takes the TX byte |
| rx_count | output | $clog2(RX_DEPTH+1) | RX FIFO fill level |
| tx_count | output | $clog2(TX_DEPTH+1) | TX FIFO fill level |
| ovr_evt | output | 1 | One-cycle overrun pulse |

## Verification
The bench builds the router with both FIFO depths set to 4. This makes full-queue conditions reachable within a few pushes: receiver backpressure in normal and remote loopback modes, and dropped CPU pushes with their overrun pulse in normal and local loopback modes. Holding `tx_ready` low lets the TX FIFO collect bytes from normal, echo and remote loopback paths. The scoreboard then checks their order as the FIFO drains.

// File: rtl/uart_chan_router.sv
module uart_chan_router #(
  parameter int DW = 8,
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16,
  localparam int RXA = $clog2(RX_DEPTH),
  localparam int TXA = $clog2(TX_DEPTH),
  localparam int RXC = $clog2(RX_DEPTH + 1),
  localparam int TXC = $clog2(TX_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     chmode,
  input  logic           ctrl_wr,
  input  logic [8:0]     ctrl_wdata,
  output logic [8:0]     ctrl_q,
  input  logic           rx_valid,
  input  logic [DW-1:0]  rx_data,
  output logic           rx_ready,
  input  logic           dr_wr,
  input  logic [DW-1:0]  dr_wdata,
  input  logic           dr_rd,
  output logic [DW-1:0]  dr_rdata,
  output logic           tx_valid,
  output logic [DW-1:0]  tx_data,
  input  logic           tx_ready,
  output logic [RXC-1:0] rx_count,
  output logic [TXC-1:0] tx_count,
  output logic           ovr_evt
);
  localparam logic [8:0] CTRL_INIT = 9'h128;
  localparam logic [RXC-1:0] RX_FULLV = RXC'(RX_DEPTH);
  localparam logic [TXC-1:0] TX_FULLV = TXC'(TX_DEPTH);

  logic [8:0] ctrl_r;
  logic [DW-1:0] rxm [RX_DEPTH];
  logic [DW-1:0] txm [TX_DEPTH];
  logic [RXA-1:0] rx_wp, rx_rp;
  logic [TXA-1:0] tx_wp, tx_rp;
  logic [RXC-1:0] rx_cnt;
  logic [TXC-1:0] tx_cnt;

  wire m_norm = chmode == 2'd0;
  wire m_echo = chmode == 2'd1;
  wire m_llb  = chmode == 2'd2;
  wire m_rlb  = chmode == 2'd3;

  wire rx_on = ctrl_r[2] & ~ctrl_r[3];
  wire tx_on = ctrl_r[4] & ~ctrl_r[5];
  wire rx_flush = ctrl_wr & ctrl_wdata[0];
  wire tx_flush = ctrl_wr & ctrl_wdata[1];

  wire rx_full = rx_cnt == RX_FULLV;
  wire tx_full = tx_cnt == TX_FULLV;

  assign rx_ready = ((m_norm | m_echo) ? ~rx_full : 1'b1) &
                    ((m_echo | m_rlb)  ? ~tx_full : 1'b1);
  wire rx_hs = rx_valid & rx_ready;

  wire rx_req = (rx_hs & (m_norm | m_echo)) | (dr_wr & m_llb);
  wire tx_req = (rx_hs & (m_echo | m_rlb)) | (dr_wr & m_norm);
  wire [DW-1:0] rx_din = m_llb  ? dr_wdata : rx_data;
  wire [DW-1:0] tx_din = m_norm ? dr_wdata : rx_data;

  wire rx_push = rx_req & rx_on & ~rx_full;
  wire tx_push = tx_req & tx_on & ~tx_full;
  wire rx_ovf  = rx_req & rx_on & rx_full;
  wire tx_ovf  = tx_req & tx_on & tx_full;
  wire rx_pop  = dr_rd & rx_on & (rx_cnt != '0);
  wire tx_pop  = tx_valid & tx_ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_r <= CTRL_INIT;
    else if (ctrl_wr) ctrl_r <= {ctrl_wdata[8:2], 2'b00};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ovr_evt <= 1'b0;
    else ovr_evt <= rx_ovf | tx_ovf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + RXC'(rx_push) - RXC'(rx_pop);
    end

  always_ff @(posedge clk)
    if (rx_push && !rx_flush) rxm[rx_wp] <= rx_din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + TXC'(tx_push) - TXC'(tx_pop);
    end

  always_ff @(posedge clk)
    if (tx_push && !tx_flush) txm[tx_wp] <= tx_din;

  assign ctrl_q   = ctrl_r;
  assign rx_count = rx_cnt;
  assign tx_count = tx_cnt;
  assign tx_valid = tx_cnt != '0;
  assign tx_data  = txm[tx_rp];
  assign dr_rdata = (rx_on && rx_cnt != '0) ? rxm[rx_rp] : '0;
endmodule

module uart_chan_router_chk #(
  parameter int DW = 8,
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16,
  localparam int RXC = $clog2(RX_DEPTH + 1),
  localparam int TXC = $clog2(TX_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     chmode,
  input logic           ctrl_wr,
  input logic [8:0]     ctrl_wdata,
  input logic [8:0]     ctrl_q,
  input logic           rx_ready,
  input logic           dr_wr,
  input logic [DW-1:0]  dr_rdata,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic [RXC-1:0] rx_count,
  input logic [TXC-1:0] tx_count,
  input logic           ovr_evt
);
  wire rx_off = ctrl_q[3] | ~ctrl_q[2];
  wire tx_off = ctrl_q[5] | ~ctrl_q[4];

  assert_llb_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chmode == 2'd2 |-> rx_ready);
  assert_rx_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= RXC'(RX_DEPTH));
  assert_tx_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= TXC'(TX_DEPTH));
  assert_rx_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && ctrl_wdata[0] |=> rx_count == '0);
  assert_rx_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_off && !(ctrl_wr && ctrl_wdata[0]) |=> $stable(rx_count));
  assert_tx_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_off && !(ctrl_wr && ctrl_wdata[1]) && !(tx_valid && tx_ready) |=> $stable(tx_count));
  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count == '0 |-> dr_rdata == '0);
  assert_ovr_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |-> $past(dr_wr));
endmodule

bind uart_chan_router uart_chan_router_chk #(.DW(DW), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .chmode(chmode), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
  .ctrl_q(ctrl_q), .rx_ready(rx_ready), .dr_wr(dr_wr), .dr_rdata(dr_rdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_count(rx_count), .tx_count(tx_count),
  .ovr_evt(ovr_evt)
);

// File: tb/uart_chan_router_test.sv
module uart_chan_router_test;
  localparam int DW = 8;
  localparam int D = 4;
  localparam int C = $clog2(D + 1);
  localparam logic [8:0] EN = 9'h114;

  logic clk = 0, rst_n = 0;
  logic [1:0] chmode = 0;
  logic ctrl_wr = 0; logic [8:0] ctrl_wdata = 0; logic [8:0] ctrl_q;
  logic rx_valid = 0; logic [DW-1:0] rx_data = 0; logic rx_ready;
  logic dr_wr = 0; logic [DW-1:0] dr_wdata = 0; logic dr_rd = 0; logic [DW-1:0] dr_rdata;
  logic tx_valid; logic [DW-1:0] tx_data; logic tx_ready = 0;
  logic [C-1:0] rx_count, tx_count; logic ovr_evt;
  int checks = 0, fails = 0;
  logic [DW-1:0] expq [$];

  always #4 clk = ~clk;

  uart_chan_router #(.DW(DW), .RX_DEPTH(D), .TX_DEPTH(D)) uut (.*);

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [8:0] v);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic send_rx(logic [DW-1:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic cpu_wr(logic [DW-1:0] b);
    @(negedge clk); dr_wr = 1; dr_wdata = b;
    @(negedge clk); dr_wr = 0;
  endtask

  task automatic cpu_rd(output logic [DW-1:0] b);
    @(negedge clk); dr_rd = 1; #1 b = dr_rdata;
    @(negedge clk); dr_rd = 0;
  endtask

  always @(negedge clk)
    if (rst_n && tx_valid && tx_ready) begin
      if (expq.size() == 0) chk("R10", tx_data, -1, "unexpected tx byte");
      else chk("R10", tx_data, expq.pop_front(), "tx byte order");
    end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [DW-1:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", ctrl_q, 9'h128, "ctrl reset");
    chk("R1", rx_count, 0, "rx count reset");
    chk("R1", tx_valid, 0, "tx_valid reset");

    wr_ctrl(EN);
    chk("R6", ctrl_q, EN, "ctrl enable readback");

    // R2 normal
    send_rx(8'hA1); send_rx(8'hA2);
    chk("R2", rx_count, 2, "rx fill normal");
    cpu_wr(8'h55); expq.push_back(8'h55);
    chk("R2", tx_count, 1, "tx fill normal");
    cpu_rd(b); chk("R8", b, 8'hA1, "first read");
    cpu_rd(b); chk("R8", b, 8'hA2, "second read");
    cpu_rd(b); chk("R8", b, 0, "empty read");

    // R5 and R9 on RX
    for (int i = 0; i < D; i++) send_rx(8'h10 + 8'(i));
    chk("R5", rx_ready, 0, "ready low rx full normal");
    chmode = 2'd2; #1;
    chk("R5", rx_ready, 1, "ready high local loopback");
    cpu_wr(8'hEE);
    chk("R9", ovr_evt, 1, "overrun on full rx");
    chk("R9", rx_count, D, "count after overrun");
    @(negedge clk); chk("R9", ovr_evt, 0, "overrun one cycle");
    wr_ctrl(EN | 9'h001);
    chk("R7", rx_count, 0, "rx flush");
    chk("R7", ctrl_q, EN, "flush bit reads 0");

    // R4 local loopback
    cpu_wr(8'h3C);
    chk("R4", rx_count, 1, "llb write into rx");
    chk("R4", tx_count, 1, "llb tx untouched");
    send_rx(8'h99);
    chk("R4", rx_count, 1, "llb rx byte discarded");
    cpu_rd(b); chk("R4", b, 8'h3C, "llb read data");

    // R3 echo
    chmode = 2'd1;
    send_rx(8'h77); expq.push_back(8'h77);
    chk("R3", rx_count, 1, "echo rx push");
    chk("R3", tx_count, 2, "echo tx push");
    cpu_wr(8'h66);
    chk("R3", tx_count, 2, "echo cpu write dropped");
    cpu_rd(b); chk("R3", b, 8'h77, "echo rx data");

    // R4 remote loopback, R5 tx backpressure
    chmode = 2'd3;
    send_rx(8'h88); expq.push_back(8'h88);
    chk("R4", rx_count, 0, "rlb rx untouched");
    send_rx(8'h99); expq.push_back(8'h99);
    chk("R4", tx_count, D, "rlb tx fill");
    cpu_wr(8'h44);
    chk("R4", tx_count, D, "rlb cpu write dropped");
    chk("R5", rx_ready, 0, "ready low tx full rlb");
    chmode = 2'd0;
    cpu_wr(8'hAA);
    chk("R9", ovr_evt, 1, "overrun on full tx");
    tx_ready = 1;
    for (int i = 0; i < 20 && tx_count != 0; i++) @(negedge clk);
    tx_ready = 0;
    chk("R10", tx_count, 0, "tx drained");
    chk("R10", expq.size(), 0, "all bytes seen");

    // R6 gating
    send_rx(8'h11);
    wr_ctrl(9'h13C);
    cpu_rd(b); chk("R6", b, 0, "read while rx disabled");
    chk("R6", rx_count, 1, "pop ignored");
    send_rx(8'h33);
    chk("R6", rx_count, 1, "push ignored");
    cpu_wr(8'h22);
    chk("R6", tx_count, 0, "tx push ignored");
    wr_ctrl(EN);
    cpu_rd(b); chk("R6", b, 8'h11, "data kept while disabled");

    // R7 tx flush
    cpu_wr(8'h5A);
    chk("R7", tx_count, 1, "tx before flush");
    wr_ctrl(EN | 9'h002);
    chk("R7", tx_count, 0, "tx flush");
    chk("R7", ctrl_q, EN, "tx flush bit reads 0");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule